// File: doc/BRIEF.md
# Conditional Branch Condition Evaluator

This block decides whether a conditional branch goes. It keeps a four-bit status register holding zero, carry, sign and overflow flags. A flag-setting operation can load that register. A compare loads it from the subtraction of operand B from operand A. A test loads it from the bitwise AND of the two operands. In both cases the arithmetic result itself is thrown away.

A 4-bit condition code selects one of sixteen predicates over the stored flags. There are eight plain flag tests, four unsigned magnitude tests and four signed magnitude tests. The block reports whether the branch is taken. It also gives the next program counter: the supplied target when taken, and the current PC plus one otherwise.

The status register is written on the clock edge. The branch evaluation is combinational and reads the flags as they stood before that edge. A compare and a dependent branch in the same cycle therefore see the older flags. Decoding of instructions and the PC register itself belong to the surrounding pipeline.

Top module: `brc_unit`

## Requirements
- R1: While reset is asserted, and after it is released, all four stored flags read 0 until the first flag write. flags_o bit 3 is Z, bit 2 is C, bit 1 is S and bit 0 is V.
- R2: On a clock edge with flg_we=1 and flg_test=0 (compare), the flags load from A−B. Z=1 when A equals B. S is the MSB of the difference. C=1 when no borrow occurs (A ≥ B unsigned). V=1 on two's-complement overflow of the subtraction.
- R3: On a clock edge with flg_we=1 and flg_test=1 (test), Z=1 when A AND B is zero, S is the MSB of A AND B, and C and V are cleared.
- R4: On a clock edge with flg_we=0 the stored flags do not change, whatever the operand inputs carry.
- R5: Codes 0 to 7 test single flags: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 S=0 (plus), 5 S=1 (minus), 6 V=1, 7 V=0.
- R6: Codes 8 to 11 are the unsigned tests: 8 higher (C=1 and Z=0), 9 higher-or-equal (C=1), 10 lower (C=0), 11 lower-or-equal (C=0 or Z=1).
- R7: Codes 12 to 15 are the signed tests: 12 greater (S XOR V = 0 and Z=0), 13 greater-or-equal (S XOR V = 0), 14 less (S XOR V = 1), 15 less-or-equal (S XOR V = 1 or Z=1).
- R8: Equal and not-equal use codes 0 and 1. After a compare, code 0 is taken exactly when A equals B, and code 1 exactly when they differ.
- R9: next_pc equals target when taken is 1, and pc plus 1 when taken is 0.
- R10: The PC increment wraps modulo 2^PC_W, so an all-ones pc with a branch not taken gives next_pc 0.
- R11: A branch evaluated in the same cycle as a flag write uses the flags stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flg_we | input | 1 | Load the status flags at this edge |
| flg_test | input | 1 | 1 selects test (AND), 0 selects compare (A−B) |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B |
| cond | input | 4 | Condition code |
| pc | input | PC_W | Current program counter |
| target | input | PC_W | Branch target address |
| flags_o | output | 4 | Stored flags {Z, C, S, V} |
| taken | output | 1 | Branch condition holds |
| next_pc | output | PC_W | Address of the next instruction |

## Verification
Random operand pairs cover mixed signs, so the unsigned and signed codes disagree often. Comparing those two families shows whether carry and overflow are handled apart. About a quarter of the compares use equal operands, which exercises the Z-dependent codes (higher, less-or-equal, equal) and separates them from their non-strict partners. Directed pairs are chosen for specific flag cases:
- the most negative value minus one, which overflows;
- zero minus one, which borrows;
- disjoint and overlapping AND masks for the test form.

An all-ones pc checks the wrap of the increment. A flag write issued together with a branch shows whether the evaluation reads the old flags or the new ones.

// File: rtl/brc_pkg.sv
package brc_pkg;

  typedef struct packed {
    logic z;
    logic c;
    logic s;
    logic v;
  } flags_t;

  localparam int NCOND = 16;

  typedef enum logic [3:0] {
    CC_Z, CC_NZ, CC_C, CC_NC, CC_P, CC_M, CC_V, CC_NV,
    CC_HI, CC_HE, CC_LO, CC_LOE, CC_GT, CC_GE, CC_LT, CC_LE
  } cond_e;

  // One predicate over the stored flags, selected by the condition code.
  function automatic logic cond_hit(input logic [3:0] code, input flags_t f);
    logic lt_s;
    lt_s = f.s ^ f.v;
    case (cond_e'(code))
      CC_Z:    cond_hit = f.z;
      CC_NZ:   cond_hit = !f.z;
      CC_C:    cond_hit = f.c;
      CC_NC:   cond_hit = !f.c;
      CC_P:    cond_hit = !f.s;
      CC_M:    cond_hit = f.s;
      CC_V:    cond_hit = f.v;
      CC_NV:   cond_hit = !f.v;
      CC_HI:   cond_hit = f.c && !f.z;
      CC_HE:   cond_hit = f.c;
      CC_LO:   cond_hit = !f.c;
      CC_LOE:  cond_hit = !f.c || f.z;
      CC_GT:   cond_hit = !lt_s && !f.z;
      CC_GE:   cond_hit = !lt_s;
      CC_LT:   cond_hit = lt_s;
      default: cond_hit = lt_s || f.z;
    endcase
  endfunction

endpackage

// File: rtl/brc_flag_gen.sv
module brc_flag_gen
  import brc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              is_test,
  output flags_t            f
);
  localparam int MSB = DATA_W - 1;

  function automatic flags_t sub_flags(input logic [DATA_W-1:0] x,
                                       input logic [DATA_W-1:0] y);
    logic [DATA_W:0] wide;
    flags_t r;
    wide = {1'b0, x} - {1'b0, y};
    r.z  = (wide[MSB:0] == '0);
    r.c  = !wide[DATA_W];
    r.s  = wide[MSB];
    r.v  = (x[MSB] != y[MSB]) && (wide[MSB] != x[MSB]);
    return r;
  endfunction

  function automatic flags_t and_flags(input logic [DATA_W-1:0] x,
                                       input logic [DATA_W-1:0] y);
    logic [DATA_W-1:0] m;
    flags_t r;
    m   = x & y;
    r.z = (m == '0);
    r.c = 1'b0;
    r.s = m[MSB];
    r.v = 1'b0;
    return r;
  endfunction

  flags_t cmp_f;
  flags_t tst_f;

  assign cmp_f = sub_flags(a, b);
  assign tst_f = and_flags(a, b);
  assign f     = is_test ? tst_f : cmp_f;

endmodule

// File: rtl/brc_flag_reg.sv
module brc_flag_reg
  import brc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   we,
  input  flags_t d,
  output flags_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
(
  input  flags_t            f,
  input  logic [3:0]        code,
  output logic [NCOND-1:0]  hits,
  output logic              hit
);
  for (genvar i = 0; i < NCOND; i++) begin : g_pred
    assign hits[i] = cond_hit(4'(i), f);
  end

  assign hit = hits[code];
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flg_we,
  input  logic              flg_test,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        cond,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   target,
  output logic [3:0]        flags_o,
  output logic              taken,
  output logic [PC_W-1:0]   next_pc
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  flags_t             flags_new;
  flags_t             flags_q;
  logic [NCOND-1:0]   cond_vec;
  logic [PC_W-1:0]    seq_pc;

  brc_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .a       (opa),
    .b       (opb),
    .is_test (flg_test),
    .f       (flags_new)
  );

  brc_flag_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (flg_we),
    .d     (flags_new),
    .q     (flags_q)
  );

  brc_cond_eval u_eval (
    .f    (flags_q),
    .code (cond),
    .hits (cond_vec),
    .hit  (taken)
  );

  assign seq_pc  = pc + PC_STEP;
  assign next_pc = taken ? target : seq_pc;
  assign flags_o = flags_q;

endmodule

// File: rtl/brc_unit_chk.sv
module brc_unit_chk #(
  parameter int DATA_W = 16,
  parameter int PC_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flg_we,
  input logic              flg_test,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [3:0]        flags_o,
  input logic [15:0]       cond_vec
);
  // R2
  cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && !flg_test) |=> (flags_o[2] == ($past(opa) >= $past(opb))));

  // R8
  cmp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && !flg_test) |=> (flags_o[3] == ($past(opa) == $past(opb))));

  // R7
  cmp_signed_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && !flg_test) |=>
      ((flags_o[1] ^ flags_o[0]) == ($signed($past(opa)) < $signed($past(opb)))));

  // R3
  test_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_we && flg_test) |=> (flags_o[2] == 1'b0 && flags_o[0] == 1'b0));

  // R4
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flg_we |=> $stable(flags_o));

  // R5
  zero_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vec[0] != cond_vec[1]);

  // R6
  higher_in_he_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vec[8] |-> (cond_vec[9] && !cond_vec[11]));

  // R7
  greater_in_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_vec[12] |-> (cond_vec[13] && !cond_vec[15]));
endmodule

bind brc_unit brc_unit_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flg_we   (flg_we),
  .flg_test (flg_test),
  .opa      (opa),
  .opb      (opb),
  .flags_o  (flags_o),
  .cond_vec (cond_vec)
);

// File: tb/sim_brc_unit.sv
`timescale 1ns/1ps
module sim_brc_unit;
  localparam int DW = 16;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flg_we = 1'b0;
  logic          flg_test = 1'b0;
  logic [DW-1:0] opa = '0;
  logic [DW-1:0] opb = '0;
  logic [3:0]    cond = 4'd0;
  logic [PW-1:0] pc = '0;
  logic [PW-1:0] target = '0;
  logic [3:0]    flags_o;
  logic          taken;
  logic [PW-1:0] next_pc;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] mdl = 4'b0000;  // {Z,C,S,V}

  always #4 clk = ~clk;

  brc_unit #(.DATA_W(DW), .PC_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .flg_we(flg_we), .flg_test(flg_test),
    .opa(opa), .opb(opb), .cond(cond), .pc(pc), .target(target),
    .flags_o(flags_o), .taken(taken), .next_pc(next_pc)
  );

  // Expected flags: compare via signed/unsigned integer arithmetic, test via mask.
  function automatic logic [3:0] exp_flags(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic tst);
    logic [DW-1:0] d;
    int sa, sb, sd;
    if (tst) begin
      d = a & b;
      return {d == 0, 1'b0, d[DW-1], 1'b0};
    end
    d  = a - b;
    sa = $signed(a);
    sb = $signed(b);
    sd = sa - sb;
    return {a == b, int'(a) >= int'(b), d[DW-1],
            (sd > 32767) || (sd < -32768)};
  endfunction

  function automatic logic exp_hit(input logic [3:0] c, input logic [3:0] f);
    logic z, cy, s, v, neg;
    {z, cy, s, v} = f;
    neg = (s != v);
    case (c)
      4'd0:  return z == 1'b1;
      4'd1:  return z == 1'b0;
      4'd2:  return cy == 1'b1;
      4'd3:  return cy == 1'b0;
      4'd4:  return s == 1'b0;
      4'd5:  return s == 1'b1;
      4'd6:  return v == 1'b1;
      4'd7:  return v == 1'b0;
      4'd8:  return (cy & ~z) == 1'b1;
      4'd9:  return cy == 1'b1;
      4'd10: return cy == 1'b0;
      4'd11: return (~cy | z) == 1'b1;
      4'd12: return (~neg & ~z) == 1'b1;
      4'd13: return neg == 1'b0;
      4'd14: return neg == 1'b1;
      default: return (neg | z) == 1'b1;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic string cond_tag(input logic [3:0] c);
    if (c < 4'd8)  return "R5";
    if (c < 4'd12) return "R6";
    return "R7";
  endfunction

  // One cycle: drive at negedge, check combinational outputs, then flags after the edge.
  task automatic step(input logic we, input logic tst, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic [3:0] c,
                      input logic [PW-1:0] p, input logic [PW-1:0] t,
                      input string tag_override);
    logic eh;
    @(negedge clk);
    flg_we = we; flg_test = tst; opa = a; opb = b; cond = c; pc = p; target = t;
    #1;
    eh = exp_hit(c, mdl);
    check((tag_override != "") ? tag_override : cond_tag(c), 32'(taken), 32'(eh));
    check("R9", 32'(next_pc), 32'(eh ? t : PW'(p + 1'b1)));
    @(posedge clk);
    if (we) mdl = exp_flags(a, b, tst);
    #1;
    check(!we ? "R4" : (tst ? "R3" : "R2"), 32'(flags_o), 32'(mdl));
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    // R1: reset state
    cond = 4'd1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", 32'(flags_o), 32'd0);
    check("R1", 32'(taken), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", 32'(flags_o), 32'd0);

    // R8: equal operands, then unequal
    step(1'b1, 1'b0, 16'h1234, 16'h1234, 4'd0, 16'h0010, 16'h0100, "");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd0, 16'h0011, 16'h0200, "R8");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd8, 16'h0012, 16'h0200, "R6");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd15, 16'h0013, 16'h0200, "R7");
    // R11: write unequal compare while branching on the old Z=1
    step(1'b1, 1'b0, 16'h0001, 16'h0002, 4'd0, 16'h0014, 16'h0300, "R11");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd1, 16'h0015, 16'h0300, "R8");
    // borrow: 0 - 1
    step(1'b1, 1'b0, 16'h0000, 16'h0001, 4'd10, 16'h0020, 16'h0400, "");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd10, 16'h0021, 16'h0400, "R6");
    // signed overflow: most negative minus one
    step(1'b1, 1'b0, 16'h8000, 16'h0001, 4'd6, 16'h0030, 16'h0500, "");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd6, 16'h0031, 16'h0500, "R2");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd14, 16'h0032, 16'h0500, "R7");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd9, 16'h0033, 16'h0500, "R6");
    // test: disjoint masks then overlapping MSB
    step(1'b1, 1'b1, 16'hF0F0, 16'h0F0F, 4'd0, 16'h0040, 16'h0600, "");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd0, 16'h0041, 16'h0600, "R3");
    step(1'b1, 1'b1, 16'hFFFF, 16'h8001, 4'd5, 16'h0042, 16'h0600, "");
    step(1'b0, 1'b0, 16'h0000, 16'h0000, 4'd5, 16'h0043, 16'h0600, "R3");
    // R10: all-ones pc, branch not taken (S=1 so plus fails)
    step(1'b0, 1'b0, 16'hAAAA, 16'h5555, 4'd4, 16'hFFFF, 16'h0700, "R5");
    check("R10", 32'(next_pc), 32'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] a, b;
      a = DW'($urandom);
      b = ($urandom_range(3) == 0) ? a : DW'($urandom);
      step($urandom_range(3) != 0, $urandom_range(3) == 0, a, b,
           4'($urandom), PW'($urandom), PW'($urandom), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule